// File: doc/BRIEF.md
# Ring Buffer Write-Pointer Resume Controller

This block owns the write side of a ring buffer that holds incoming audio samples in external memory, so that playback can ride out interruptions of the source. It keeps two addresses: the live write address, which advances with every accepted sample, and a verified write address, which follows the live one until a compare-connect start is requested and then stays frozen at the last sample known to be good. Encoding, which means writing samples, stops when the buffer reports full or when a command clears the write-enable bit.

When a command sets write-enable again, the block decides where writing resumes. Before any compare-connect start has been requested, writing continues at the live address, so samples already stored past the verified point are kept. After a compare-connect start, writing restarts at the verified address, either because the command arrives while the compare is still pending (direct connection) or because the match flag arrives first. Once a match has restarted the sequence, a later write-enable has no effect. The record that a compare was ever requested is sticky and is cleared only by reset or by a command that powers the buffer function down.

Top module: `wpr_resume_ctrl`

## Requirements
- R1: After reset, enc_active is 0, wr_req is 0 and wr_addr is 0.
- R2: wr_req is high exactly when encode is active, din_vld is high, buf_full is low and no address jump takes place in that cycle. Each cycle with wr_req high advances wr_addr by one on the next clock edge. In any other cycle without a jump or a power-down, wr_addr holds its value.
- R3: wr_addr always stays below DEPTH. A write at address DEPTH-1 wraps it to 0.
- R4: buf_full high clears encode on the next edge, and no write request is issued while buf_full is high.
- R5: A command with cmd_pwr=1 and cmd_wen=1 issued before any compare-connect start turns encode on and leaves wr_addr where it was.
- R6: A command with cmd_pwr=1 and cmd_wen=1 issued while a compare-connect start is pending (no match yet) turns encode on and moves wr_addr to the verified address. The verified address is the value of wr_addr after the last write accepted while no compare was pending.
- R7: match_det high while a compare is pending turns encode on and moves wr_addr to the verified address. This ends the pending compare.
- R8: After a compare has been requested and its pending state has ended, a command with cmd_wen=1 changes neither enc_active nor wr_addr. The power bit of that command is still applied.
- R9: A command with cmd_pwr=0 clears encode, both addresses and the compare record on the next edge. A later command with cmd_pwr=1 and cmd_wen=1 then starts encode at address 0.
- R10: cmp_stb is ignored while the buffer function is powered down, and match_det is ignored while no compare is pending.
- R11: A command with cmd_pwr=1 and cmd_wen=0 clears encode on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Control command strobe |
| cmd_pwr | input | 1 | Command bit: buffer function powered |
| cmd_wen | input | 1 | Command bit: write enable |
| cmp_stb | input | 1 | Compare-connect start strobe |
| match_det | input | 1 | Compare engine found a match |
| buf_full | input | 1 | Buffer is full |
| din_vld | input | 1 | Incoming sample valid |
| wr_addr | output | $clog2(DEPTH) | Active write address |
| enc_active | output | 1 | Encode (write) sequence running |
| wr_req | output | 1 | Write the current sample at wr_addr |

## Verification
The assertions assume that the strobes are single-cycle events and that commands, compare starts and match flags never fall in the same cycle, because the block defines no ordering between them. The bench drives at most one event per operation and puts an idle cycle after each, so every operation starts from a settled state. The random phase draws data writes, full pulses, commands, compare starts, matches and rare power-downs from a fixed seed. Around it, directed sequences force each resume case and the address wrap.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  // Per-cycle decisions passed from the control FSM to the address datapath
  typedef struct packed {
    logic clr;     // power-down: clear both addresses
    logic jump;    // move the live address to the verified address
    logic accept;  // a sample is written this cycle
    logic track;   // verified address follows accepted writes
  } wpr_ctl_t;
endpackage

// File: rtl/wpr_rst_sync.sv
module wpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
  import wpr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_stb,
  input  logic     cmd_pwr,
  input  logic     cmd_wen,
  input  logic     cmp_stb,
  input  logic     match_det,
  input  logic     buf_full,
  input  logic     din_vld,
  output logic     enc_active,
  output wpr_ctl_t ctl
);
  logic pwr_q, enc_q, seen_q, pend_q;
  logic pwr_n, enc_n, seen_n, pend_n;
  logic clr;

  assign clr = cmd_stb & ~cmd_pwr;

  always_comb begin
    pwr_n    = pwr_q;
    enc_n    = enc_q;
    seen_n   = seen_q;
    pend_n   = pend_q;
    ctl.clr  = clr;
    ctl.jump = 1'b0;
    if (clr) begin
      pwr_n  = 1'b0;
      enc_n  = 1'b0;
      seen_n = 1'b0;
      pend_n = 1'b0;
    end else begin
      if (cmd_stb) pwr_n = 1'b1;
      if (pwr_q && cmp_stb && !pend_q) begin
        seen_n = 1'b1;
        pend_n = 1'b1;
      end
      if (pend_q && match_det) begin
        enc_n    = 1'b1;
        pend_n   = 1'b0;
        ctl.jump = 1'b1;
      end
      if (cmd_stb && cmd_wen) begin
        if (!seen_q) begin
          enc_n = 1'b1;
        end else if (pend_q) begin
          enc_n    = 1'b1;
          pend_n   = 1'b0;
          ctl.jump = 1'b1;
        end
      end
      if (cmd_stb && !cmd_wen) enc_n = 1'b0;
      if (buf_full)            enc_n = 1'b0;
    end
    ctl.accept = enc_q & din_vld & ~buf_full & ~ctl.jump & ~clr;
    ctl.track  = ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      enc_q  <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_n;
      enc_q  <= enc_n;
      seen_q <= seen_n;
      pend_q <= pend_n;
    end
  end

  assign enc_active = enc_q;
endmodule

// File: rtl/wpr_addr.sv
module wpr_addr
  import wpr_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wpr_ctl_t      ctl,
  output logic [AW-1:0] wr_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wa_q, vwa_q, wa_n, vwa_n, wa_inc;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wa_inc = wa_q + AW'(1);
    end else begin : g_mod
      assign wa_inc = (wa_q == LAST) ? '0 : wa_q + AW'(1);
    end
  endgenerate

  always_comb begin
    wa_n  = wa_q;
    vwa_n = vwa_q;
    if (ctl.clr) begin
      wa_n  = '0;
      vwa_n = '0;
    end else if (ctl.jump) begin
      wa_n = vwa_q;
    end else if (ctl.accept) begin
      wa_n = wa_inc;
      if (ctl.track) vwa_n = wa_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q  <= '0;
      vwa_q <= '0;
    end else begin
      wa_q  <= wa_n;
      vwa_q <= vwa_n;
    end
  end

  assign wr_addr = wa_q;
endmodule

// File: rtl/wpr_resume_ctrl.sv
module wpr_resume_ctrl
  import wpr_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic          cmd_pwr,
  input  logic          cmd_wen,
  input  logic          cmp_stb,
  input  logic          match_det,
  input  logic          buf_full,
  input  logic          din_vld,
  output logic [AW-1:0] wr_addr,
  output logic          enc_active,
  output logic          wr_req
);
  logic     rst_sync_n;
  wpr_ctl_t ctl;
  logic     jump_w;

  wpr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  wpr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_stb   (cmd_stb),
    .cmd_pwr   (cmd_pwr),
    .cmd_wen   (cmd_wen),
    .cmp_stb   (cmp_stb),
    .match_det (match_det),
    .buf_full  (buf_full),
    .din_vld   (din_vld),
    .enc_active(enc_active),
    .ctl       (ctl)
  );

  wpr_addr #(.DEPTH(DEPTH)) u_addr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ctl    (ctl),
    .wr_addr(wr_addr)
  );

  assign wr_req = ctl.accept;
  assign jump_w = ctl.jump;
endmodule

// File: rtl/wpr_resume_chk.sv
module wpr_resume_chk #(
  parameter int DEPTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_stb,
  input logic          cmd_pwr,
  input logic          buf_full,
  input logic          din_vld,
  input logic [AW-1:0] wr_addr,
  input logic          enc_active,
  input logic          wr_req,
  input logic          jump
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic clr;
  assign clr = cmd_stb & ~cmd_pwr;

  // R2: a write request needs running encode, valid data and room
  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (enc_active && din_vld && !buf_full));

  // R2: an accepted write below the last slot steps the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !clr && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + AW'(1)));

  // R2: without a write, jump or power-down the address holds
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !jump && !clr) |=> $stable(wr_addr));

  // R3: a write at the last slot wraps to zero
  a_r3_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !clr && wr_addr == LAST) |=> (wr_addr == '0));

  // R3: the address stays inside the buffer
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr <= LAST);

  // R4: full halts encode
  a_r4_full_stops: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> !enc_active);

  // R9: power-down clears encode and address
  a_r9_pwr_down: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!enc_active && wr_addr == '0));
endmodule

bind wpr_resume_ctrl wpr_resume_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_stb   (cmd_stb),
  .cmd_pwr   (cmd_pwr),
  .buf_full  (buf_full),
  .din_vld   (din_vld),
  .wr_addr   (wr_addr),
  .enc_active(enc_active),
  .wr_req    (wr_req),
  .jump      (jump_w)
);

// File: tb/test_wpr_resume_ctrl.sv
`timescale 1ns/1ps
module test_wpr_resume_ctrl;
  localparam int DEPTH = 12;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stb = 0, cmd_pwr = 0, cmd_wen = 0, cmp_stb = 0;
  logic match_det = 0, buf_full = 0, din_vld = 0;
  logic [AW-1:0] wr_addr;
  logic enc_active, wr_req;

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  bit m_pwr, m_enc, m_seen, m_pend;
  int m_wa, m_vwa;

  always #2.5 clk = ~clk;

  wpr_resume_ctrl #(.DEPTH(DEPTH)) i_wpr_resume_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_pwr(cmd_pwr),
    .cmd_wen(cmd_wen), .cmp_stb(cmp_stb), .match_det(match_det),
    .buf_full(buf_full), .din_vld(din_vld), .wr_addr(wr_addr),
    .enc_active(enc_active), .wr_req(wr_req)
  );

  function automatic int wrap_inc(int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one operation: drive, check request, clock, release, check state
  task automatic op(string tag, bit c, bit p, bit w, bit cm, bit mt, bit v, bit f);
    bit clr, jmp, acc;
    @(negedge clk);
    cmd_stb = c; cmd_pwr = p; cmd_wen = w; cmp_stb = cm;
    match_det = mt; din_vld = v; buf_full = f;
    clr = c && !p;
    jmp = !clr && m_pend && (mt || (c && w && m_seen));
    acc = m_enc && v && !f && !jmp && !clr;
    #1;
    chk(tag, "wr_req", int'(wr_req), int'(acc));
    if (clr) begin
      m_pwr = 0; m_enc = 0; m_seen = 0; m_pend = 0; m_wa = 0; m_vwa = 0;
    end else begin
      bit pend_old = m_pend;
      bit seen_old = m_seen;
      if (jmp) m_wa = m_vwa;
      else if (acc) begin
        m_wa = wrap_inc(m_wa);
        if (!pend_old) m_vwa = m_wa;
      end
      if (m_pwr && cm && !pend_old) begin m_seen = 1; m_pend = 1; end
      if (pend_old && mt) begin m_enc = 1; m_pend = 0; end
      if (c && w) begin
        if (!seen_old) m_enc = 1;
        else if (pend_old) begin m_enc = 1; m_pend = 0; end
      end
      if (c) m_pwr = 1;
      if (c && !w) m_enc = 0;
      if (f) m_enc = 0;
    end
    @(negedge clk);
    cmd_stb = 0; cmd_pwr = 0; cmd_wen = 0; cmp_stb = 0;
    match_det = 0; din_vld = 0; buf_full = 0;
    chk(tag, "enc_active", int'(enc_active), int'(m_enc));
    chk(tag, "wr_addr", int'(wr_addr), m_wa);
  endtask

  task automatic writes(string tag, int n);
    for (int i = 0; i < n; i++) op(tag, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_pwr = 0; m_enc = 0; m_seen = 0; m_pend = 0; m_wa = 0; m_vwa = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "enc_active", int'(enc_active), 0);
    chk("R1", "wr_req", int'(wr_req), 0);
    chk("R1", "wr_addr", int'(wr_addr), 0);

    op("R5", 1, 1, 1, 0, 0, 0, 0);          // power on, write enable
    writes("R2", 5);
    chk("R2", "wr_addr literal", int'(wr_addr), 5);
    op("R4", 0, 0, 0, 0, 0, 1, 1);          // full with data: no request
    op("R4", 0, 0, 0, 0, 0, 1, 0);          // disabled: no request
    op("R5", 1, 1, 1, 0, 0, 0, 0);          // resume without compare
    chk("R5", "wr_addr literal", int'(wr_addr), 5);
    writes("R2", 2);
    op("R10", 0, 0, 0, 0, 1, 0, 0);         // match without compare ignored
    op("R6", 0, 0, 0, 1, 0, 0, 0);          // compare start, verified = 7
    writes("R6", 3);
    op("R4", 0, 0, 0, 0, 0, 0, 1);
    op("R6", 1, 1, 1, 0, 0, 0, 0);          // resume while pending
    chk("R6", "wr_addr literal", int'(wr_addr), 7);
    writes("R3", 3);
    op("R7", 0, 0, 0, 1, 0, 0, 0);          // compare start, verified = 10
    writes("R3", 2);                        // 11 then wrap to 0
    chk("R3", "wr_addr literal", int'(wr_addr), 0);
    op("R4", 0, 0, 0, 0, 0, 0, 1);
    op("R7", 0, 0, 0, 0, 1, 0, 0);          // match restarts at verified
    chk("R7", "wr_addr literal", int'(wr_addr), 10);
    writes("R7", 1);
    op("R4", 0, 0, 0, 0, 0, 0, 1);
    op("R8", 1, 1, 1, 0, 0, 0, 0);          // re-enable after match: no effect
    chk("R8", "enc_active literal", int'(enc_active), 0);
    op("R10", 0, 0, 0, 0, 1, 0, 0);
    op("R9", 1, 0, 1, 0, 0, 0, 0);          // power down
    op("R10", 0, 0, 0, 1, 0, 0, 0);         // compare while unpowered ignored
    op("R9", 1, 1, 1, 0, 0, 0, 0);          // record cleared: starts at 0
    chk("R9", "enc_active literal", int'(enc_active), 1);
    writes("R10", 3);
    op("R11", 1, 1, 0, 0, 0, 0, 0);         // write enable cleared
    op("R11", 0, 0, 0, 0, 0, 1, 0);
    op("R10", 1, 1, 1, 0, 0, 0, 0);         // still plain resume at 3
    chk("R10", "wr_addr literal", int'(wr_addr), 3);

    for (int k = 0; k < 600; k++) begin
      int sel = $urandom % 40;
      if (sel < 20)       op("R2", 0, 0, 0, 0, 0, 1, 0);
      else if (sel < 23)  op("R4", 0, 0, 0, 0, 0, $urandom % 2, 1);
      else if (sel < 28)  op("R6", 1, 1, 1, 0, 0, 0, 0);
      else if (sel < 30)  op("R11", 1, 1, 0, 0, 0, 0, 0);
      else if (sel < 34)  op("R7", 0, 0, 0, 1, 0, 0, 0);
      else if (sel < 39)  op("R7", 0, 0, 0, 0, 1, 0, 0);
      else                op("R9", 1, 0, $urandom % 2, 0, 0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule